// File: doc/BRIEF.md
# Bridge Inbound Cycle Retry Controller

This block sits on the inbound path of a bus bridge. A backplane master hands it one cycle at a time: address, write data and command. The block issues that cycle on the local host bus and waits for the local target to end it with a termination code. Without auto-retry, a local retry goes straight back upstream. With auto-retry on, the block reissues the same cycle by itself after every local retry. It keeps doing so until the target ends the cycle another way, or until a programmable reissue cap is used up.

Once the outcome is settled, the block presents one upstream response: OK, RETRY or BUS ERROR. It holds that response until the backplane side takes it with a valid/ready handshake. A separate protocol option decides what a cap overrun turns into: a retry when the option is on, a bus error when it is off. Three control settings live in a small configuration register, loaded by a write strobe: auto-retry on/off, the protocol option and the 4-bit cap.

The controller is a five-state machine:
- IDLE: ready for a request. On an accepted request it goes to ISSUE.
- ISSUE: drives the local request for one clock, then goes to WAIT.
- WAIT: waits for the local termination. A termination that calls for a reissue leads to GAP; any other leads to RESP.
- GAP: one idle clock, then back to ISSUE.
- RESP: presents the upstream response. On the handshake it returns to IDLE.

Top module: `inbound_retry_ctrl`

## Requirements
- R1: After reset, up_req_ready is 1 and up_rsp_valid and loc_req_valid are 0. The configuration after reset is auto-retry on, protocol option off and cap 8.
- R2: Local termination codes on loc_term are 2'b00 normal, 2'b01 retry, 2'b10 disconnect and 2'b11 target-abort. Upstream codes on up_rsp are 2'b00 OK, 2'b01 RETRY and 2'b10 BERR. A normal end or a disconnect gives OK. A target-abort gives BERR.
- R3: With auto-retry off, a local retry ends the cycle after its single issue, with upstream RETRY.
- R4: With auto-retry on, each local retry within the cap causes a reissue of the same cycle. The first non-retry termination ends the cycle and is mapped as in R2.
- R5: At most cap reissues happen per cycle. A retry that arrives once the cap is reached gives RETRY if the protocol option is on and BERR if it is off, even though auto-retry is on.
- R6: The reissue count restarts at zero for every accepted upstream request.
- R7: Each reissue asserts loc_req_valid no earlier than the second clock after the retry termination, so at least one idle clock lies between them. loc_addr, loc_wdata and loc_cmd stay constant from acceptance until the response is taken.
- R8: Only one cycle is in flight at a time. up_req_ready is 0 from acceptance until the response handshake. A pending response holds up_rsp constant while up_rsp_ready is 0.
- R9: The configuration register loads on cfg_we. A cap of 0 means no reissue at all, so the first local retry produces the cap-overrun response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load strobe for the configuration register |
| cfg_auto_retry | input | 1 | Auto-retry enable value to load |
| cfg_retry_proto | input | 1 | Cap-overrun option value: 1 RETRY, 0 BERR |
| cfg_limit | input | LIMIT_W | Reissue cap value to load |
| up_req_valid | input | 1 | Backplane request valid |
| up_req_ready | output | 1 | Block can accept a request |
| up_addr | input | ADDR_W | Request address |
| up_wdata | input | DATA_W | Request write data |
| up_cmd | input | CMD_W | Request command |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rsp_ready | input | 1 | Upstream response taken |
| up_rsp | output | 2 | Upstream response code |
| loc_req_valid | output | 1 | Local bus cycle issue pulse |
| loc_addr | output | ADDR_W | Local cycle address |
| loc_wdata | output | DATA_W | Local cycle write data |
| loc_cmd | output | CMD_W | Local cycle command |
| loc_term_valid | input | 1 | Local termination valid |
| loc_term | input | 2 | Local termination code |

## Verification
A request accepted at a clock edge shows loc_req_valid on the very next clock. A termination sampled in WAIT produces one of two things. It either raises up_rsp_valid one clock later, or it shows the next issue two clocks later, after a single idle clock in GAP. The bench drives every input at the falling edge and samples every output at the falling edge. It logs the falling-edge index of each termination it gives and measures the distance to the next issue against that index. It compares the response code, and the total number of issues, against values worked out from the cap, the options and the termination script of each transaction.

// File: rtl/irc_pkg.sv
package irc_pkg;

    typedef enum logic [1:0] {
        TERM_DONE  = 2'b00,
        TERM_RETRY = 2'b01,
        TERM_DISC  = 2'b10,
        TERM_ABORT = 2'b11
    } term_e;

    typedef enum logic [1:0] {
        RSP_OK    = 2'b00,
        RSP_RETRY = 2'b01,
        RSP_BERR  = 2'b10
    } rsp_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_GAP,
        ST_RESP
    } state_e;

endpackage

// File: rtl/irc_cfg_regs.sv
module irc_cfg_regs #(
    parameter int LIMIT_W   = 4,
    parameter int DEF_LIMIT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic               auto_in,
    input  logic               proto_in,
    input  logic [LIMIT_W-1:0] limit_in,
    output logic               auto_en,
    output logic               proto_en,
    output logic [LIMIT_W-1:0] limit
);

    localparam logic [LIMIT_W-1:0] RST_LIMIT = LIMIT_W'(DEF_LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_en  <= 1'b1;
            proto_en <= 1'b0;
            limit    <= RST_LIMIT;
        end else if (we) begin
            auto_en  <= auto_in;
            proto_en <= proto_in;
            limit    <= limit_in;
        end
    end

endmodule

// File: rtl/irc_reissue_cnt.sv
module irc_reissue_cnt #(
    parameter int LIMIT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               inc,
    input  logic [LIMIT_W-1:0] limit,
    output logic [LIMIT_W-1:0] count,
    output logic               cap_hit
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && !cap_hit) begin
            count <= count + 1'b1;
        end
    end

    // A cap lowered mid-cycle still stops reissue at once
    assign cap_hit = (count >= limit);

endmodule

// File: rtl/irc_term_map.sv
module irc_term_map
    import irc_pkg::*;
(
    input  term_e term,
    input  logic  auto_en,
    input  logic  proto_en,
    input  logic  cap_hit,
    output logic  reissue,
    output rsp_e  rsp
);

    always_comb begin
        reissue = 1'b0;
        rsp     = RSP_OK;
        unique case (term)
            TERM_DONE,
            TERM_DISC:  rsp = RSP_OK;
            TERM_ABORT: rsp = RSP_BERR;
            TERM_RETRY: begin
                if (!auto_en) begin
                    rsp = RSP_RETRY;
                end else if (cap_hit) begin
                    rsp = proto_en ? RSP_RETRY : RSP_BERR;
                end else begin
                    reissue = 1'b1;
                end
            end
            default:    rsp = RSP_BERR;
        endcase
    end

endmodule

// File: rtl/inbound_retry_ctrl.sv
module inbound_retry_ctrl
    import irc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int CMD_W     = 4,
    parameter int LIMIT_W   = 4,
    parameter int DEF_LIMIT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_auto_retry,
    input  logic               cfg_retry_proto,
    input  logic [LIMIT_W-1:0] cfg_limit,
    input  logic               up_req_valid,
    output logic               up_req_ready,
    input  logic [ADDR_W-1:0]  up_addr,
    input  logic [DATA_W-1:0]  up_wdata,
    input  logic [CMD_W-1:0]   up_cmd,
    output logic               up_rsp_valid,
    input  logic               up_rsp_ready,
    output logic [1:0]         up_rsp,
    output logic               loc_req_valid,
    output logic [ADDR_W-1:0]  loc_addr,
    output logic [DATA_W-1:0]  loc_wdata,
    output logic [CMD_W-1:0]   loc_cmd,
    input  logic               loc_term_valid,
    input  logic [1:0]         loc_term
);

    state_e             state_q;
    state_e             state_d;
    logic               auto_en;
    logic               proto_en;
    logic [LIMIT_W-1:0] limit;
    logic [LIMIT_W-1:0] count;
    logic               cap_hit;
    logic               reissue;
    rsp_e               map_rsp;
    rsp_e               rsp_q;
    logic               accept;
    logic               term_seen;

    irc_cfg_regs #(
        .LIMIT_W   (LIMIT_W),
        .DEF_LIMIT (DEF_LIMIT)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .auto_in  (cfg_auto_retry),
        .proto_in (cfg_retry_proto),
        .limit_in (cfg_limit),
        .auto_en  (auto_en),
        .proto_en (proto_en),
        .limit    (limit)
    );

    irc_reissue_cnt #(
        .LIMIT_W (LIMIT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .inc     (term_seen && reissue),
        .limit   (limit),
        .count   (count),
        .cap_hit (cap_hit)
    );

    irc_term_map u_map (
        .term     (term_e'(loc_term)),
        .auto_en  (auto_en),
        .proto_en (proto_en),
        .cap_hit  (cap_hit),
        .reissue  (reissue),
        .rsp      (map_rsp)
    );

    assign accept    = (state_q == ST_IDLE) && up_req_valid;
    assign term_seen = (state_q == ST_WAIT) && loc_term_valid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (up_req_valid)   state_d = ST_ISSUE;
            ST_ISSUE:                     state_d = ST_WAIT;
            ST_WAIT:  if (loc_term_valid) state_d = reissue ? ST_GAP : ST_RESP;
            ST_GAP:                       state_d = ST_ISSUE;
            ST_RESP:  if (up_rsp_ready)   state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // Cycle hold and response capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loc_addr  <= '0;
            loc_wdata <= '0;
            loc_cmd   <= '0;
            rsp_q     <= RSP_OK;
        end else begin
            if (accept) begin
                loc_addr  <= up_addr;
                loc_wdata <= up_wdata;
                loc_cmd   <= up_cmd;
            end
            if (term_seen && !reissue) begin
                rsp_q <= map_rsp;
            end
        end
    end

    // Outputs
    always_comb begin
        up_req_ready  = (state_q == ST_IDLE);
        loc_req_valid = (state_q == ST_ISSUE);
        up_rsp_valid  = (state_q == ST_RESP);
        up_rsp        = rsp_q;
    end

endmodule

// File: rtl/irc_chk.sv
module irc_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CMD_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_req_ready,
    input logic              up_rsp_valid,
    input logic              up_rsp_ready,
    input logic [1:0]        up_rsp,
    input logic              loc_req_valid,
    input logic [ADDR_W-1:0] loc_addr,
    input logic [DATA_W-1:0] loc_wdata,
    input logic [CMD_W-1:0]  loc_cmd
);

    // R7
    issue_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_req_valid |=> !loc_req_valid);

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_req_ready && $past(!up_req_ready)) |->
        ($stable(loc_addr) && $stable(loc_wdata) && $stable(loc_cmd)));

    // R8
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rsp_valid && !up_rsp_ready) |=> (up_rsp_valid && $stable(up_rsp)));

    // R8
    single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_req_ready |-> (!up_rsp_valid && !loc_req_valid));

    // R2
    rsp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_rsp_valid |-> (up_rsp != 2'b11));

    // R8
    rsp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rsp_valid && up_rsp_ready) |=> (up_req_ready && !up_rsp_valid));

endmodule

bind inbound_retry_ctrl irc_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CMD_W  (CMD_W)
) u_chk (.*);

// File: tb/sim_inbound_retry_ctrl.sv
module sim_inbound_retry_ctrl;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 4;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_auto_retry = 1'b0;
    logic          cfg_retry_proto = 1'b0;
    logic [LW-1:0] cfg_limit = '0;
    logic          up_req_valid = 1'b0;
    logic          up_req_ready;
    logic [AW-1:0] up_addr = '0;
    logic [DW-1:0] up_wdata = '0;
    logic [CW-1:0] up_cmd = '0;
    logic          up_rsp_valid;
    logic          up_rsp_ready = 1'b0;
    logic [1:0]    up_rsp;
    logic          loc_req_valid;
    logic [AW-1:0] loc_addr;
    logic [DW-1:0] loc_wdata;
    logic [CW-1:0] loc_cmd;
    logic          loc_term_valid = 1'b0;
    logic [1:0]    loc_term = 2'b00;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit cur_auto = 1'b1;
    bit cur_proto = 1'b0;
    int cur_lim = 8;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    inbound_retry_ctrl u0 (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] map_term(input logic [1:0] t);
        return (t == 2'b11) ? 2'b10 : 2'b00;
    endfunction

    function automatic logic [1:0] exp_rsp(input bit a, input bit p, input int lim,
                                           input int nret, input logic [1:0] fin);
        if (!a) return (nret > 0) ? 2'b01 : map_term(fin);
        if (nret > lim) return p ? 2'b01 : 2'b10;
        return map_term(fin);
    endfunction

    function automatic int exp_issues(input bit a, input int lim, input int nret);
        if (!a) return 1;
        if (nret > lim) return lim + 1;
        return nret + 1;
    endfunction

    task automatic program_cfg(input bit a, input bit p, input int lim);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_auto_retry = a;
        cfg_retry_proto = p;
        cfg_limit = LW'(lim);
        @(negedge clk);
        cfg_we = 1'b0;
        cur_auto = a;
        cur_proto = p;
        cur_lim = lim;
    endtask

    // One inbound transaction: nret local retries, then final termination fin
    task automatic run_txn(input int nret, input logic [1:0] fin, input string req);
        logic [AW-1:0] a_s;
        logic [DW-1:0] d_s;
        logic [CW-1:0] c_s;
        logic [1:0]    got;
        int issues = 0;
        int given = 0;
        int last_term = -100;
        int guard = 0;
        bit done = 1'b0;
        a_s = $urandom;
        d_s = $urandom;
        c_s = CW'($urandom);
        @(negedge clk);
        up_req_valid = 1'b1;
        up_addr = a_s;
        up_wdata = d_s;
        up_cmd = c_s;
        while (!up_req_ready && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        up_req_valid = 1'b0;
        up_addr = ~a_s;
        up_wdata = ~d_s;
        chk(up_req_ready == 1'b0, "R8", "ready after accept", up_req_ready, 0);
        guard = 0;
        while (!done && guard < 400) begin
            if (loc_req_valid) begin
                issues++;
                chk(loc_addr == a_s && loc_wdata == d_s && loc_cmd == c_s, "R7",
                    "held cycle fields", loc_addr, a_s);
                if (issues > 1)
                    chk(cyc - last_term >= 2, "R7", "reissue gap", cyc - last_term, 2);
                @(negedge clk);
                repeat ($urandom_range(0, 2)) @(negedge clk);
                loc_term_valid = 1'b1;
                loc_term = (given < nret) ? 2'b01 : fin;
                if (given < nret) given++;
                last_term = cyc;
                @(negedge clk);
                loc_term_valid = 1'b0;
                loc_term = $urandom;
            end else if (up_rsp_valid) begin
                done = 1'b1;
            end else begin
                @(negedge clk);
                guard++;
            end
        end
        chk(done, req, "response arrived", done, 1);
        got = up_rsp;
        chk(got == exp_rsp(cur_auto, cur_proto, cur_lim, nret, fin), req, "response code",
            got, exp_rsp(cur_auto, cur_proto, cur_lim, nret, fin));
        chk(issues == exp_issues(cur_auto, cur_lim, nret), req, "issue count",
            issues, exp_issues(cur_auto, cur_lim, nret));
        repeat ($urandom_range(0, 3)) begin
            @(negedge clk);
            chk(up_rsp_valid && up_rsp == got && !up_req_ready, "R8", "held response",
                up_rsp, got);
        end
        up_rsp_ready = 1'b1;
        @(negedge clk);
        up_rsp_ready = 1'b0;
        chk(!up_rsp_valid && up_req_ready, "R8", "release after handshake",
            up_rsp_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        process::self().srandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(up_req_ready == 1'b1, "R1", "ready in reset", up_req_ready, 1);
        chk(up_rsp_valid == 1'b0 && loc_req_valid == 1'b0, "R1", "quiet in reset",
            up_rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(up_req_ready && !up_rsp_valid && !loc_req_valid, "R1", "idle after reset",
            up_req_ready, 1);
        // R1 default config: auto on, cap 8, option off
        run_txn(3, 2'b10, "R1");
        run_txn(9, 2'b10, "R1");
        // R2 mapping
        program_cfg(1'b1, 1'b0, 4);
        run_txn(0, 2'b00, "R2");
        run_txn(0, 2'b10, "R2");
        run_txn(0, 2'b11, "R2");
        // R3 auto-retry off
        program_cfg(1'b0, 1'b0, 4);
        run_txn(1, 2'b00, "R3");
        run_txn(5, 2'b11, "R3");
        // R4 reissue up to final term
        program_cfg(1'b1, 1'b1, 5);
        run_txn(4, 2'b11, "R4");
        run_txn(5, 2'b10, "R4");
        // R5 cap overrun with both options
        run_txn(6, 2'b00, "R5");
        program_cfg(1'b1, 1'b0, 5);
        run_txn(7, 2'b00, "R5");
        run_txn(15, 2'b00, "R5");
        // R6 count restarts per cycle
        program_cfg(1'b1, 1'b0, 2);
        run_txn(2, 2'b10, "R6");
        run_txn(2, 2'b10, "R6");
        // R9 cap of zero, and maximum cap
        program_cfg(1'b1, 1'b1, 0);
        run_txn(1, 2'b00, "R9");
        run_txn(0, 2'b10, "R9");
        program_cfg(1'b1, 1'b0, 15);
        run_txn(15, 2'b11, "R9");
        run_txn(16, 2'b00, "R9");
        // Random mix
        for (int i = 0; i < 60; i++) begin
            logic [1:0] fin;
            fin = 2'($urandom_range(0, 2));
            if (fin == 2'b01) fin = 2'b11;
            if ($urandom_range(0, 3) == 0)
                program_cfg(1'($urandom), 1'($urandom), $urandom_range(0, 15));
            run_txn($urandom_range(0, 17), fin, "R4");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule